// File: doc/BRIEF.md
# Third-Order Sinc Decimator with Source-Switch Settling

This block turns a single-bit sigma-delta modulator stream into signed 16-bit conversion results. Three cascaded integrators run at the modulator rate, one sample per clock. Three cascaded differentiators run at the decimated rate. The decimation ratio is a power of two, programmed as an exponent, so one design covers a wide span of output data rates.

A three-way input-source select chooses what the analog front end converts: the external voltage, the external temperature sensor or the internal temperature sensor. The select is passed out as a one-hot route for the front-end multiplexer. Changing the source or the ratio at run time restarts the filter from a cleared state. The block then withholds results until the filter window holds only samples taken after the change. Software sees only settled data, plus a busy flag that shows the settling window.

Top module: `sinc3_settle_decim`

## Requirements
- R1: `src_sel` codes are 0 = external voltage, 1 = external temperature, 2 = internal temperature. Code 3 is reserved and behaves exactly like code 2. Moving between codes 2 and 3 causes no restart. `src_route` is one-hot: bit 0 for code 0, bit 1 for code 1, bit 2 for codes 2 and 3. It changes on the clock edge that takes the new code.
- R2: The decimation ratio is 2^s. Here s is `dec_shift` clamped into [MIN_SHIFT, MAX_SHIFT], which defaults to [5, 8]. Once settled, `result_vld` pulses exactly once every 2^s accepted samples.
- R3: A settled result is the sinc3 output, normalised so that a ones-density d maps to (2d-1)*32768 and saturated to [-32768, 32767]. An input of all ones gives 32767. All zeros gives -32768. Alternating bits give 0. Three ones in four give 16384. One one in four gives -16384.
- R4: A change of the effective source clears all filter state on the edge that sees it, and the sample at that edge is discarded. The first `result_vld` follows the 3*2^s-th later accepted sample. The two decimated outputs before it produce no strobe.
- R5: A change of the raw `dec_shift` value restarts the filter in the same way as R4, using the new ratio.
- R6: `settling` rises on a restart and stays high until the first settled strobe. It is low in the cycle `result_vld` is high. `result_vld` is never high while `settling` is high.
- R7: While `en` is low, the filter state is held cleared, `result_vld` stays low and `settling` stays high. The sample on the first edge with `en` high is accepted, so the first strobe follows 3*2^s accepted samples.
- R8: `result_vld` is high for exactly one clock per result.
- R9: After reset, `result` is 0, `result_vld` is 0 and `settling` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock, one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Filter enable; low holds the filter cleared |
| mod_bit | input | 1 | Modulator output bit (1 = +1, 0 = -1) |
| dec_shift | input | 4 | Decimation exponent s, ratio 2^s after clamping |
| src_sel | input | 2 | Input source code (see R1) |
| src_route | output | 3 | One-hot source route to the front-end multiplexer |
| result | output | 16 | Signed settled conversion result |
| result_vld | output | 1 | One-clock strobe for a new settled result |
| settling | output | 1 | High while results are withheld |

## Verification
The hardest case to reach is a restart that lands exactly where a decimated output would otherwise have fallen. A second hard case is the reserved source code, which must leave the running filter untouched. The bench changes the source at a negedge and counts edges to the first strobe, which must come exactly 3*2^s+1 edges later. It also moves between codes 2 and 3 right after a strobe and checks that the next strobe keeps its spacing of 2^s and that `settling` never rises. Constant-density bit patterns whose period divides the ratio give exact expected results, so the bench can compare them without a reference model.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

   localparam int ORDER = 3;
   localparam int RES_W = 16;

   typedef enum logic [1:0] {
      SRC_EXT_VOLT = 2'd0,
      SRC_EXT_TEMP = 2'd1,
      SRC_INT_TEMP = 2'd2,
      SRC_RSVD     = 2'd3
   } src_code_e;

   // Reserved code folds onto the internal temperature sensor.
   function automatic logic [1:0] fold_src(input logic [1:0] code);
      return (code == SRC_RSVD) ? SRC_INT_TEMP : code;
   endfunction

   function automatic logic [2:0] route_of(input logic [1:0] code);
      logic [2:0] r;
      r = 3'b000;
      r[fold_src(code)] = 1'b1;
      return r;
   endfunction

endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
   import sinc3_pkg::*;
#(
   parameter int MIN_SHIFT = 5,
   parameter int MAX_SHIFT = 8,
   parameter int SW        = $clog2(MAX_SHIFT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [1:0]    src_sel,
   input  logic [SW-1:0] shift_in,
   output logic          clear,
   output logic          sample,
   output logic          dec_tick,
   output logic          release_o,
   output logic          busy_o,
   output logic [SW-1:0] shift_act,
   output logic [2:0]    route
);

   localparam int CW = MAX_SHIFT + 1;
   localparam logic [1:0] SETTLE_N = 2'd3;

   logic [1:0]    src_q;
   logic [SW-1:0] shift_q;
   logic [CW-1:0] cnt;
   logic [CW-1:0] last_cnt;
   logic [1:0]    settle_cnt;
   logic [1:0]    src_eff;
   logic          restart;

   assign src_eff = fold_src(src_sel);
   assign restart = (src_eff != src_q) || (shift_in != shift_q);
   assign clear   = !en || restart;
   assign sample  = en && !restart;

   always_comb begin
      if (shift_q < SW'(MIN_SHIFT))      shift_act = SW'(MIN_SHIFT);
      else if (shift_q > SW'(MAX_SHIFT)) shift_act = SW'(MAX_SHIFT);
      else                               shift_act = shift_q;
   end

   assign last_cnt  = (CW'(1) << shift_act) - CW'(1);
   assign dec_tick  = sample && (cnt == last_cnt);
   assign release_o = dec_tick && (settle_cnt <= 2'd1);
   assign busy_o    = (settle_cnt != 2'd0);
   assign route     = route_of(src_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q   <= SRC_EXT_VOLT;
         shift_q <= SW'(MIN_SHIFT);
      end else begin
         src_q   <= src_eff;
         shift_q <= shift_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         settle_cnt <= SETTLE_N;
      end else if (clear) begin
         cnt        <= '0;
         settle_cnt <= SETTLE_N;
      end else if (sample) begin
         cnt <= dec_tick ? '0 : cnt + CW'(1);
         if (dec_tick && settle_cnt != 2'd0)
            settle_cnt <= settle_cnt - 2'd1;
      end
   end

   // R4: a new effective source always reopens the settling window
   assert_src_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (src_eff != src_q) |=> busy_o);

   // R5: a new ratio setting always reopens the settling window
   assert_ratio_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_in != shift_q) |=> busy_o);

   // R1: the route is always exactly one source
   assert_route_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(route) == 1);

endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ
   import sinc3_pkg::*;
#(
   parameter int AW = 26
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 sample,
   input  logic                 bit_in,
   output logic signed [AW-1:0] sum_o
);

   logic signed [AW-1:0] acc [ORDER];
   logic signed [AW-1:0] nxt [ORDER];
   logic signed [AW-1:0] x;

   assign x = bit_in ? AW'(1) : '1;

   for (genvar k = 0; k < ORDER; k++) begin : g_stage
      if (k == 0) begin : g_first
         assign nxt[k] = acc[k] + x;
      end else begin : g_rest
         assign nxt[k] = acc[k] + nxt[k-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      acc[k] <= '0;
         else if (clear)  acc[k] <= '0;
         else if (sample) acc[k] <= nxt[k];
      end
   end

   assign sum_o = nxt[ORDER-1];

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb
   import sinc3_pkg::*;
#(
   parameter int AW = 26
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 tick,
   input  logic signed [AW-1:0] sum_i,
   output logic signed [AW-1:0] diff_o
);

   logic signed [AW-1:0] dly [ORDER];
   logic signed [AW-1:0] stg [ORDER+1];

   assign stg[0] = sum_i;

   for (genvar k = 0; k < ORDER; k++) begin : g_stage
      assign stg[k+1] = stg[k] - dly[k];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     dly[k] <= '0;
         else if (clear) dly[k] <= '0;
         else if (tick)  dly[k] <= stg[k];
      end
   end

   assign diff_o = stg[ORDER];

endmodule

// File: rtl/sinc3_settle_decim.sv
module sinc3_settle_decim
   import sinc3_pkg::*;
#(
   parameter int MIN_SHIFT = 5,
   parameter int MAX_SHIFT = 8,
   parameter int SW        = $clog2(MAX_SHIFT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              mod_bit,
   input  logic [SW-1:0]     dec_shift,
   input  logic [1:0]        src_sel,
   output logic [2:0]        src_route,
   output logic [RES_W-1:0]  result,
   output logic              result_vld,
   output logic              settling
);

   localparam int AW = 2 + ORDER * MAX_SHIFT;
   localparam int RES_MAX = (1 << (RES_W - 1)) - 1;
   localparam int RES_MIN = -(1 << (RES_W - 1));

   if (MIN_SHIFT * ORDER < RES_W - 1) begin : g_chk_min
      $error("MIN_SHIFT too small for the result width");
   end
   if (MAX_SHIFT < MIN_SHIFT) begin : g_chk_order
      $error("MAX_SHIFT below MIN_SHIFT");
   end
   if (AW > 62) begin : g_chk_max
      $error("MAX_SHIFT too large");
   end

   logic                 clear, sample, dec_tick, rel;
   logic [SW-1:0]        shift_act;
   logic signed [AW-1:0] sum, diff, scaled;
   int                   sh;

   sinc3_ctrl #(.MIN_SHIFT(MIN_SHIFT), .MAX_SHIFT(MAX_SHIFT), .SW(SW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .en(en), .src_sel(src_sel), .shift_in(dec_shift),
      .clear(clear), .sample(sample), .dec_tick(dec_tick), .release_o(rel),
      .busy_o(settling), .shift_act(shift_act), .route(src_route)
   );

   sinc3_integ #(.AW(AW)) u_integ (
      .clk(clk), .rst_n(rst_n), .clear(clear), .sample(sample),
      .bit_in(mod_bit), .sum_o(sum)
   );

   sinc3_comb #(.AW(AW)) u_comb (
      .clk(clk), .rst_n(rst_n), .clear(clear), .tick(dec_tick),
      .sum_i(sum), .diff_o(diff)
   );

   always_comb begin
      sh     = ORDER * int'(shift_act) - (RES_W - 1);
      scaled = diff >>> sh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result     <= '0;
         result_vld <= 1'b0;
      end else begin
         result_vld <= rel;
         if (rel) begin
            if (scaled > AW'(RES_MAX))      result <= RES_W'(RES_MAX);
            else if (scaled < AW'(RES_MIN)) result <= RES_W'(RES_MIN);
            else                            result <= scaled[RES_W-1:0];
         end
      end
   end

   // R6: no result is released inside the settling window
   assert_no_strobe_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      result_vld |-> !settling);

   // R8: each result strobe is a single clock wide
   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      result_vld |=> !result_vld);

   // R7: a disabled filter emits nothing
   assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!result_vld && settling));

endmodule

// File: tb/sinc3_settle_decim_bench.sv
module sinc3_settle_decim_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b1;
   logic        mod_bit = 1'b1;
   logic [3:0]  dec_shift = 4'd5;
   logic [1:0]  src_sel = 2'd0;
   logic [2:0]  src_route;
   logic [15:0] result;
   logic        result_vld;
   logic        settling;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int pmode  = 1;     // 0 zeros, 1 ones, 2 alternate, 3 three-of-four, 4 one-of-four
   int phase  = 0;
   logic prev_vld = 1'b0;

   always #10 clk = ~clk;

   sinc3_settle_decim u_sinc3_settle_decim (
      .clk(clk), .rst_n(rst_n), .en(en), .mod_bit(mod_bit), .dec_shift(dec_shift),
      .src_sel(src_sel), .src_route(src_route), .result(result),
      .result_vld(result_vld), .settling(settling)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         check(1'b0, "watchdog", cycles, 150000);
         report();
      end
   end

   // Pattern driver
   always @(negedge clk) begin
      phase <= (phase + 1) % 4;
      case (pmode)
         0: mod_bit <= 1'b0;
         1: mod_bit <= 1'b1;
         2: mod_bit <= phase[0];
         3: mod_bit <= (phase != 0);
         default: mod_bit <= (phase == 0);
      endcase
   end

   // R8: no two consecutive strobe samples
   always @(negedge clk) begin
      if (rst_n && result_vld && prev_vld)
         check(1'b0, "R8 strobe width", 2, 1);
      prev_vld <= result_vld;
   end

   // Wait at negedges for the strobe; k = number of negedges taken
   task automatic wait_vld(input int limit, output int k);
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!result_vld && k < limit);
      if (!result_vld) k = -1;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(result == 16'd0, "R9 result", int'(result), 0);
      check(result_vld == 1'b0, "R9 vld", int'(result_vld), 0);
      check(settling == 1'b1, "R9 settling", int'(settling), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(src_route == 3'b001, "R1 route code0", int'(src_route), 1);
   endtask

   task automatic t_source_switch();
      int k;
      pmode = 1;
      src_sel = 2'd1;
      @(negedge clk);
      check(settling == 1'b1, "R6 busy after switch", int'(settling), 1);
      check(src_route == 3'b010, "R1 route code1", int'(src_route), 2);
      wait_vld(2000, k);
      check(k == 96, "R4 latency after switch", k + 1, 97);
      check(settling == 1'b0, "R6 busy at strobe", int'(settling), 0);
      check($signed(result) == 32767, "R3 all ones", int'($signed(result)), 32767);
      wait_vld(2000, k);
      check(k == 32, "R2 period 32", k, 32);
   endtask

   task automatic t_pattern(input int mode, input int exp);
      int k;
      pmode = mode;
      src_sel = (src_sel == 2'd0) ? 2'd1 : 2'd0;
      wait_vld(2000, k);
      check(k == 97, "R4 latency pattern", k, 97);
      check($signed(result) == exp, "R3 pattern value", int'($signed(result)), exp);
   endtask

   task automatic t_reserved_code();
      int k;
      pmode = 1;
      src_sel = 2'd2;
      wait_vld(2000, k);
      check(src_route == 3'b100, "R1 route code2", int'(src_route), 4);
      src_sel = 2'd3;
      @(negedge clk);
      check(settling == 1'b0, "R1 code3 no restart", int'(settling), 0);
      wait_vld(2000, k);
      check(k == 31, "R1 code3 keeps period", k + 1, 32);
      check(src_route == 3'b100, "R1 route code3", int'(src_route), 4);
      src_sel = 2'd2;
      wait_vld(2000, k);
      check(k == 32, "R1 code2 again no restart", k, 32);
   endtask

   task automatic t_ratio();
      int k;
      pmode = 1;
      dec_shift = 4'd8;
      wait_vld(5000, k);
      check(k == 769, "R5 latency ratio 256", k, 769);
      check($signed(result) == 32767, "R3 ones at 256", int'($signed(result)), 32767);
      wait_vld(5000, k);
      check(k == 256, "R2 period 256", k, 256);
      pmode = 3;
      dec_shift = 4'd15;
      wait_vld(5000, k);
      check(k == 769, "R2 clamp high latency", k, 769);
      check($signed(result) == 16384, "R3 three-of-four at 256", int'($signed(result)), 16384);
      pmode = 1;
      dec_shift = 4'd0;
      wait_vld(5000, k);
      check(k == 97, "R2 clamp low latency", k, 97);
      wait_vld(5000, k);
      check(k == 32, "R2 clamp low period", k, 32);
   endtask

   task automatic t_enable();
      int k;
      int seen;
      seen = 0;
      en = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (result_vld) seen++;
      end
      check(seen == 0, "R7 no strobe while off", seen, 0);
      check(settling == 1'b1, "R7 busy while off", int'(settling), 1);
      en = 1'b1;
      wait_vld(2000, k);
      check(k == 96, "R7 latency after enable", k, 96);
      check($signed(result) == 32767, "R7 value after enable", int'($signed(result)), 32767);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_source_switch();
      t_pattern(0, -32768);
      t_pattern(2, 0);
      t_pattern(3, 16384);
      t_pattern(4, -16384);
      t_reserved_code();
      t_ratio();
      t_enable();
      report();
   end

endmodule